// File: doc/BRIEF.md
# Synthesizer Divider Configuration Front End

This block is the digital front end that programs the dividers of an integer-N frequency synthesizer. Divider settings can be written through any one of three interfaces, chosen by two select inputs: a serial shift port, an 8-bit parallel bus with one write strobe per field group, or a set of direct pins. The settings are a prescaler-enable flag (active low; high bypasses the prescaler), a 9-bit main counter M, a 6-bit reference divider R and a 4-bit swallow counter A. Together they form a 20-bit word.

Two copies of that word are kept: a primary register that writes land in, and a secondary register that takes a copy of the primary on a hop event. This lets software prepare the next channel and then switch to it in one step. An 8-bit enhancement register is loaded from the serial port or from the bus. The counter outputs are taken from the primary or the secondary register, as chosen by a per-interface select line. In direct mode they are taken from the direct pins.

All interface inputs are asynchronous to the system clock. They are passed through a synchronizer and edge-detected, so every register update happens in the system clock domain.

Top module: `pll_prog_if`

## Requirements
- R1: After reset the primary, secondary and enhancement registers are all zero. With all select inputs low, every divider output and `enh_cfg` read zero.
- R2: Mode decode works as follows. `sel_direct`=1 selects direct mode whatever `sel_serial` is. Otherwise `sel_serial`=1 selects serial mode and `sel_serial`=0 selects parallel mode.
- R3: In serial mode, a rising `ser_clk` while `ser_load_n` is low shifts `ser_dat` into bit 0 of the primary word, moving the other bits up one place. The word layout is bit 19 prescaler enable, bits 18:10 M, bits 9:4 R and bits 3:0 A, so the first of 20 bits ends in the prescaler-enable bit. Bits shifted past bit 19 are lost. `ser_clk` edges while `ser_load_n` is high have no effect.
- R4: In serial mode with `enh_wr` held high, shifted bits enter the 8-bit enhancement register MSB-first instead, and the primary word is untouched.
- R5: The whole primary word is copied into the secondary register on a rising `ser_load_n` in serial mode, or on a rising `wr_hop` in parallel mode. At no other time does the secondary register change.
- R6: In parallel mode the strobes write fields from `bus_d` as follows. Rising `wr_m1` loads bit 7 into the prescaler enable and bits 6:0 into M[6:0]. Rising `wr_m2` loads bits 3:2 into R[5:4] and bits 1:0 into M[8:7], and ignores bits 7:4. Rising `wr_a` loads bits 7:4 into R[3:0] and bits 3:0 into A. Fields not named by a strobe keep their value.
- R7: In parallel mode a rising `enh_wr` loads `bus_d` into the enhancement register.
- R8: The outputs show the primary word when the select of the active interface is 1 and the secondary word when it is 0. That select is `sel_pri_ser` in serial mode and `sel_pri_par` in parallel mode.
- R9: In direct mode the outputs follow `dir_word`, which uses the same bit layout as R3. All strobes and serial lines are ignored, so the primary, secondary and enhancement registers keep their values.
- R10: Lines of the interface that is not selected are ignored. Serial activity changes nothing in parallel mode. `wr_m1`, `wr_hop` and bus-loaded `enh_wr` edges change nothing in serial mode.
- R11: With `SYNC_STAGES`=2, a write strobe edge that occurs just before a clock edge changes the outputs after the third rising clock edge (SYNC_STAGES+1), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_direct | input | 1 | 1 selects direct mode |
| sel_serial | input | 1 | With sel_direct low: 1 serial, 0 parallel |
| sel_pri_ser | input | 1 | Serial mode source select, 1 primary / 0 secondary |
| sel_pri_par | input | 1 | Parallel mode source select, 1 primary / 0 secondary |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_load_n | input | 1 | Serial load enable, low to shift; rising edge performs hop |
| enh_wr | input | 1 | Serial: level selecting enhancement target; parallel: enhancement strobe |
| wr_m1 | input | 1 | Strobe: prescaler enable and M[6:0] |
| wr_m2 | input | 1 | Strobe: R[5:4] and M[8:7] |
| wr_a | input | 1 | Strobe: R[3:0] and A |
| wr_hop | input | 1 | Strobe: copy primary into secondary |
| bus_d | input | 8 | Parallel data bus |
| dir_word | input | 20 | Direct-mode divider word |
| pre_en_n | output | 1 | Active prescaler enable (low = prescaler in use) |
| m_div | output | 9 | Active M counter value |
| r_div | output | 6 | Active reference divider value |
| a_div | output | 4 | Active A counter value |
| enh_cfg | output | 8 | Enhancement register contents |

## Verification
The bench builds the block with the default of two synchronizer stages. This makes the update latency a fixed three clocks, which is measured edge by edge for one parallel strobe. Over-long serial words, the unused upper bits of the second M strobe, hops in both interfaces and the ignoring of inactive or overridden interfaces are each checked at the outputs.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;

    localparam int M_W    = 9;
    localparam int R_W    = 6;
    localparam int A_W    = 4;
    localparam int WORD_W = 1 + M_W + R_W + A_W;
    localparam int BUS_W  = 8;
    localparam int ENH_W  = 8;

    // Field split used by the parallel strobes
    localparam int M_LO_W = BUS_W - 1;          // M bits carried by first M strobe
    localparam int M_HI_W = M_W - M_LO_W;       // M bits carried by second M strobe
    localparam int R_LO_W = BUS_W - A_W;        // R bits carried by A strobe
    localparam int R_HI_W = R_W - R_LO_W;       // R bits carried by second M strobe

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_DIR = 2'd2
    } if_mode_e;

    typedef struct packed {
        logic           pe_n;
        logic [M_W-1:0] m;
        logic [R_W-1:0] r;
        logic [A_W-1:0] a;
    } div_word_t;

    typedef struct packed {
        div_word_t        pri;
        div_word_t        sec;
        logic [ENH_W-1:0] enh;
    } cfg_regs_t;

endpackage

// File: rtl/pll_in_sync.sv
module pll_in_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign lvl = pipe_q[STAGES-1];

endmodule

// File: rtl/pll_edge_det.sv
module pll_edge_det #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_rise
            assign rise[g] = lvl[g] & ~prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/pll_reg_core.sv
module pll_reg_core
    import pll_prog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_shift_pri,
    input  logic             ev_shift_enh,
    input  logic             ev_m1,
    input  logic             ev_m2,
    input  logic             ev_a,
    input  logic             ev_enh_par,
    input  logic             ev_hop,
    input  logic             ser_bit,
    input  logic [BUS_W-1:0] bus,
    output cfg_regs_t        regs_q
);

    cfg_regs_t         regs_d;
    logic [WORD_W-1:0] pri_vec;

    assign pri_vec = regs_q.pri;

    always_comb begin
        regs_d = regs_q;
        if (ev_shift_pri) begin
            regs_d.pri = div_word_t'({pri_vec[WORD_W-2:0], ser_bit});
        end
        if (ev_shift_enh) begin
            regs_d.enh = {regs_q.enh[ENH_W-2:0], ser_bit};
        end
        if (ev_m1) begin
            regs_d.pri.pe_n           = bus[BUS_W-1];
            regs_d.pri.m[M_LO_W-1:0]  = bus[M_LO_W-1:0];
        end
        if (ev_m2) begin
            regs_d.pri.r[R_W-1:R_LO_W] = bus[M_HI_W+R_HI_W-1:M_HI_W];
            regs_d.pri.m[M_W-1:M_LO_W] = bus[M_HI_W-1:0];
        end
        if (ev_a) begin
            regs_d.pri.r[R_LO_W-1:0] = bus[BUS_W-1:A_W];
            regs_d.pri.a             = bus[A_W-1:0];
        end
        if (ev_enh_par) begin
            regs_d.enh = bus;
        end
        if (ev_hop) begin
            regs_d.sec = regs_q.pri;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/pll_out_sel.sv
module pll_out_sel
    import pll_prog_pkg::*;
(
    input  if_mode_e  mode,
    input  logic      sel_pri_ser,
    input  logic      sel_pri_par,
    input  div_word_t pri,
    input  div_word_t sec,
    input  div_word_t dir,
    output div_word_t act
);

    always_comb begin
        unique case (mode)
            MODE_DIR: act = dir;
            MODE_SER: act = sel_pri_ser ? pri : sec;
            default:  act = sel_pri_par ? pri : sec;
        endcase
    end

endmodule

// File: rtl/pll_prog_if.sv
module pll_prog_if
    import pll_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_direct,
    input  logic              sel_serial,
    input  logic              sel_pri_ser,
    input  logic              sel_pri_par,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_load_n,
    input  logic              enh_wr,
    input  logic              wr_m1,
    input  logic              wr_m2,
    input  logic              wr_a,
    input  logic              wr_hop,
    input  logic [BUS_W-1:0]  bus_d,
    input  logic [WORD_W-1:0] dir_word,
    output logic              pre_en_n,
    output logic [M_W-1:0]    m_div,
    output logic [R_W-1:0]    r_div,
    output logic [A_W-1:0]    a_div,
    output logic [ENH_W-1:0]  enh_cfg
);

    localparam int STRB_W = 7;
    localparam int LVL_W  = 5 + STRB_W;

    logic [LVL_W-1:0]  lvl_in, lvl_s;
    logic [STRB_W-1:0] strb_s, strb_r;
    logic [BUS_W-1:0]  bus_s;
    logic [WORD_W-1:0] dir_s;

    assign lvl_in = {sel_direct, sel_serial, sel_pri_ser, sel_pri_par, ser_dat,
                     ser_clk, ser_load_n, enh_wr, wr_m1, wr_m2, wr_a, wr_hop};

    pll_in_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .din(lvl_in), .lvl(lvl_s)
    );

    pll_in_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .din(bus_d), .lvl(bus_s)
    );

    pll_in_sync #(.WIDTH(WORD_W), .STAGES(SYNC_STAGES)) u_sync_dir (
        .clk(clk), .rst_n(rst_n), .din(dir_word), .lvl(dir_s)
    );

    assign strb_s = lvl_s[STRB_W-1:0];

    pll_edge_det #(.WIDTH(STRB_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(strb_s), .rise(strb_r)
    );

    // Synchronized levels
    logic s_dir, s_ser, s_pri_ser, s_pri_par, s_dat, s_load_n, s_enh;
    assign s_dir     = lvl_s[11];
    assign s_ser     = lvl_s[10];
    assign s_pri_ser = lvl_s[9];
    assign s_pri_par = lvl_s[8];
    assign s_dat     = lvl_s[7];
    assign s_load_n  = lvl_s[5];
    assign s_enh     = lvl_s[4];

    // Detected rising edges
    logic r_sclk, r_load, r_enh, r_m1, r_m2, r_a, r_hop;
    assign r_sclk = strb_r[6];
    assign r_load = strb_r[5];
    assign r_enh  = strb_r[4];
    assign r_m1   = strb_r[3];
    assign r_m2   = strb_r[2];
    assign r_a    = strb_r[1];
    assign r_hop  = strb_r[0];

    if_mode_e mode;
    logic is_ser, is_par, ev_shift;
    logic ev_shift_pri, ev_shift_enh, ev_m1, ev_m2, ev_a, ev_enh_par, ev_hop;
    logic ev_pri_any, ev_enh_any;

    always_comb begin
        if (s_dir)      mode = MODE_DIR;
        else if (s_ser) mode = MODE_SER;
        else            mode = MODE_PAR;
        is_ser       = (mode == MODE_SER);
        is_par       = (mode == MODE_PAR);
        ev_shift     = is_ser & r_sclk & ~s_load_n;
        ev_shift_pri = ev_shift & ~s_enh;
        ev_shift_enh = ev_shift & s_enh;
        ev_m1        = is_par & r_m1;
        ev_m2        = is_par & r_m2;
        ev_a         = is_par & r_a;
        ev_enh_par   = is_par & r_enh;
        ev_hop       = (is_ser & r_load) | (is_par & r_hop);
        ev_pri_any   = ev_shift_pri | ev_m1 | ev_m2 | ev_a;
        ev_enh_any   = ev_shift_enh | ev_enh_par;
    end

    cfg_regs_t regs_q;

    pll_reg_core u_core (
        .clk(clk), .rst_n(rst_n),
        .ev_shift_pri(ev_shift_pri), .ev_shift_enh(ev_shift_enh),
        .ev_m1(ev_m1), .ev_m2(ev_m2), .ev_a(ev_a),
        .ev_enh_par(ev_enh_par), .ev_hop(ev_hop),
        .ser_bit(s_dat), .bus(bus_s), .regs_q(regs_q)
    );

    div_word_t act;

    pll_out_sel u_sel (
        .mode(mode), .sel_pri_ser(s_pri_ser), .sel_pri_par(s_pri_par),
        .pri(regs_q.pri), .sec(regs_q.sec), .dir(div_word_t'(dir_s)),
        .act(act)
    );

    assign pre_en_n = act.pe_n;
    assign m_div    = act.m;
    assign r_div    = act.r;
    assign a_div    = act.a;
    assign enh_cfg  = regs_q.enh;

endmodule

// File: rtl/pll_prog_chk.sv
module pll_prog_chk
    import pll_prog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input if_mode_e         mode,
    input logic             ev_hop,
    input logic             ev_pri_any,
    input logic             ev_enh_any,
    input div_word_t        pri,
    input div_word_t        sec,
    input logic [ENH_W-1:0] enh
);

    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_hop |=> $stable(sec));                                    // R5
    AST_HOP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hop |=> (sec == $past(pri)));                              // R5
    AST_PRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_pri_any |=> $stable(pri));                                // R6
    AST_ENH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_enh_any |=> $stable(enh));                                // R7
    AST_DIR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIR) |=> ($stable(pri) && $stable(sec) && $stable(enh))); // R9

endmodule

bind pll_prog_if pll_prog_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ev_hop(ev_hop),
    .ev_pri_any(ev_pri_any), .ev_enh_any(ev_enh_any),
    .pri(regs_q.pri), .sec(regs_q.sec), .enh(regs_q.enh)
);

// File: tb/pll_prog_if_test.sv
`timescale 1ns/1ps
module pll_prog_if_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_direct = 0, sel_serial = 0, sel_pri_ser = 0, sel_pri_par = 0;
    logic ser_clk = 0, ser_dat = 0, ser_load_n = 1, enh_wr = 0;
    logic wr_m1 = 0, wr_m2 = 0, wr_a = 0, wr_hop = 0;
    logic [7:0]  bus_d = '0;
    logic [19:0] dir_word = '0;
    logic        pre_en_n;
    logic [8:0]  m_div;
    logic [5:0]  r_div;
    logic [3:0]  a_div;
    logic [7:0]  enh_cfg;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pll_prog_if #(.SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .sel_direct(sel_direct), .sel_serial(sel_serial),
        .sel_pri_ser(sel_pri_ser), .sel_pri_par(sel_pri_par), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .ser_load_n(ser_load_n), .enh_wr(enh_wr), .wr_m1(wr_m1),
        .wr_m2(wr_m2), .wr_a(wr_a), .wr_hop(wr_hop), .bus_d(bus_d), .dir_word(dir_word),
        .pre_en_n(pre_en_n), .m_div(m_div), .r_div(r_div), .a_div(a_div), .enh_cfg(enh_cfg)
    );

    // {m1 data, m2 data, a data, expected word = {pe, M, R, A}}
    localparam logic [43:0] VEC [4] = '{
        {8'h85, 8'h0B, 8'h3C, 1'b1, 9'h185, 6'h23, 4'hC},
        {8'h7F, 8'hF0, 8'hA5, 1'b0, 9'h07F, 6'h0A, 4'h5},
        {8'h00, 8'h05, 8'hF0, 1'b0, 9'h080, 6'h1F, 4'h0},
        {8'hFF, 8'h0F, 8'hFF, 1'b1, 9'h1FF, 6'h3F, 4'hF}
    };

    localparam logic [19:0] SW  = {1'b1, 9'h0AB, 6'h15, 4'h6};
    localparam logic [19:0] SW2 = {1'b0, 9'h155, 6'h2A, 4'h9};
    localparam logic [19:0] P5  = {1'b0, 9'h180, 6'h3F, 4'hF};

    function automatic logic [19:0] out_word();
        return {pre_en_n, m_div, r_div, a_div};
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0 m1, 1 m2, 2 a, 3 enh, 4 hop
    task automatic par_strobe(input int which, input logic [7:0] d);
        bus_d = d;
        tick(3);
        case (which)
            0: wr_m1 = 1;
            1: wr_m2 = 1;
            2: wr_a = 1;
            3: enh_wr = 1;
            default: wr_hop = 1;
        endcase
        tick(4);
        wr_m1 = 0; wr_m2 = 0; wr_a = 0; enh_wr = 0; wr_hop = 0;
        tick(4);
    endtask

    task automatic ser_shift(input logic [23:0] w, input int n, input logic to_enh);
        enh_wr = to_enh;
        ser_load_n = 0;
        tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = w[i];
            tick(3);
            ser_clk = 1;
            tick(3);
            ser_clk = 0;
        end
        tick(4);
    endtask

    task automatic ser_end();
        ser_load_n = 1;
        tick(4);
        enh_wr = 0;
        tick(4);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog: got %0d cycles expected below 150000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        logic [19:0] prev;
        tick(3);
        rst_n = 1;
        tick(2);
        // R1 reset state
        check("R1 word after reset", out_word(), 20'h0);
        check("R1 enh after reset", enh_cfg, 8'h0);

        // Table walk in parallel mode: R6, R8, R5
        prev = 20'h0;
        foreach (VEC[k]) begin
            sel_pri_par = 1;
            par_strobe(0, VEC[k][43:36]);
            par_strobe(1, VEC[k][35:28]);
            par_strobe(2, VEC[k][27:20]);
            check("R6 primary fields", out_word(), VEC[k][19:0]);
            sel_pri_par = 0;
            tick(4);
            check("R8 secondary before hop", out_word(), prev);
            par_strobe(4, 8'h00);
            check("R5 secondary after wr_hop", out_word(), VEC[k][19:0]);
            prev = VEC[k][19:0];
        end

        // R11 latency of one strobe
        sel_pri_par = 1;
        bus_d = 8'h00;
        tick(4);
        wr_m1 = 1;
        tick(2);
        check("R11 no change after two edges", out_word(), 20'hFFFFF);
        tick(1);
        check("R11 change after third edge", out_word(), P5);
        wr_m1 = 0;
        tick(4);

        // R7 parallel enhancement write
        par_strobe(3, 8'h5A);
        check("R7 enh from bus", enh_cfg, 8'h5A);

        // R10 serial activity ignored in parallel mode
        ser_shift({4'h0, 20'h12345}, 20, 1'b0);
        ser_end();
        check("R10 primary kept in parallel", out_word(), P5);
        check("R10 enh kept in parallel", enh_cfg, 8'h5A);
        sel_pri_par = 0;
        tick(4);
        check("R10 secondary kept in parallel", out_word(), 20'hFFFFF);

        // R2/R8 serial mode select lines
        sel_serial = 1;
        sel_pri_ser = 1;
        tick(5);
        check("R8 serial shows primary", out_word(), P5);
        sel_pri_ser = 0;
        tick(4);
        check("R8 serial shows secondary", out_word(), 20'hFFFFF);

        // R3 serial load, R5 hop on load enable rise
        ser_shift({4'h0, SW}, 20, 1'b0);
        check("R3 secondary untouched while shifting", out_word(), 20'hFFFFF);
        sel_pri_ser = 1;
        tick(4);
        check("R3 serial word in primary", out_word(), SW);
        sel_pri_ser = 0;
        ser_end();
        check("R5 hop on load enable rise", out_word(), SW);

        // R3 over-long word keeps last 20 bits
        sel_pri_ser = 1;
        ser_shift({4'hF, SW2}, 24, 1'b0);
        ser_end();
        check("R3 overlong serial word", out_word(), SW2);

        // R3 serial clock with load enable high is ignored
        ser_dat = 1;
        tick(3);
        ser_clk = 1;
        tick(3);
        ser_clk = 0;
        tick(4);
        check("R3 clock ignored with load high", out_word(), SW2);

        // R4 serial enhancement shift
        ser_shift({16'h0, 8'hC3}, 8, 1'b1);
        check("R4 enh serial shift", enh_cfg, 8'hC3);
        check("R4 primary untouched", out_word(), SW2);
        ser_end();

        // R10 parallel strobes ignored in serial mode
        par_strobe(0, 8'h00);
        par_strobe(3, 8'hFF);
        par_strobe(4, 8'h00);
        check("R10 primary kept in serial", out_word(), SW2);
        check("R10 enh kept in serial", enh_cfg, 8'hC3);

        // R9 / R2 direct mode overrides serial
        sel_direct = 1;
        dir_word = 20'h9ABCD;
        tick(5);
        check("R9 direct word", out_word(), 20'h9ABCD);
        dir_word = 20'h13579;
        tick(5);
        check("R2 direct overrides serial", out_word(), 20'h13579);
        par_strobe(0, 8'hFF);
        par_strobe(3, 8'h00);
        par_strobe(4, 8'h00);
        ser_shift({4'h0, 20'hFFFFF}, 20, 1'b0);
        ser_end();
        sel_direct = 0;
        tick(5);
        check("R9 primary kept in direct", out_word(), SW2);
        check("R9 enh kept in direct", enh_cfg, 8'hC3);
        sel_pri_ser = 0;
        tick(4);
        check("R9 secondary kept in direct", out_word(), SW2);

        done = 1;
        summary();
        $finish;
    end

endmodule